// File: doc/BRIEF.md
# Event Timer Comparator Bank

This block holds a small set of comparator channels for a free-running event timer. Each channel keeps a 32-bit configuration word, a 64-bit comparator and a 64-bit period. Software reaches them with 32-bit register accesses that carry a channel index and a byte offset. Writes take effect at the clock edge. Read data is registered and appears on `rd_data` in the cycle after `rd_en`, and it holds its value until the next read.

Each channel compares the shared main counter with its comparator. A hit needs the global enable and an armed channel. In periodic mode a hit advances the comparator by the period. In one-shot mode a hit disarms the channel. A channel can run in a 32-bit mode if it is built with the size capability. In that mode only the low half of the counter is compared, and the comparator and period are held to 32 bits. The capability bits are fixed per channel by parameters, and they decide which configuration bits software may change.

Channel register offsets: 0x00 config low, 0x04 config high, 0x08 comparator low, 0x0C comparator high, 0x10 and 0x14 routing. Config bits: 2 pulse enable, 3 periodic, 4 periodic-capable (read-only), 5 size-capable (read-only), 6 set-value, 8 32-bit mode. Every other config bit reads 0 and cannot be written.

Top module: `evt_timer_cmp`

## Requirements
- R1: After reset, each channel's config low reads its capability bits only (bit 4 periodic-capable, bit 5 size-capable), and its comparator reads all ones in both halves. Read data appears one cycle after `rd_en`.
- R2: The periodic bit (bit 3) changes on a config write only if the channel is periodic-capable. Otherwise it keeps its value.
- R3: The 32-bit-mode bit (bit 8) reads 0 after any config write to a channel without the size capability.
- R4: A config write with bit 8 set, on a size-capable channel, clears the high 32 bits of the comparator and of the period.
- R5: A comparator-low write stores the data in the comparator's low half. In periodic mode the same value is also stored in the period's low half. In periodic 32-bit mode, bit 31 of the value is cleared first; in periodic 64-bit mode the value is stored unchanged.
- R6: Any comparator write that takes effect clears the set-value bit (bit 6).
- R7: A comparator-high write is ignored in 32-bit mode. Otherwise it sets the comparator's high half, and in periodic mode it also sets the period's high half.
- R8: Writes to config high and to both routing offsets change nothing. Reads of those offsets, and of any offset not listed, return 0.
- R9: An access with a channel index at or above `NUM_TIMERS` reads 0 and changes nothing.
- R10: A channel hits when the global enable is high, the channel is armed, and the comparator equals the counter (low 32 bits only, in 32-bit mode). `match_o` pulses for a hit only if bit 2 is set, and it stays 0 while the global enable is low.
- R11: On a periodic hit the comparator becomes comparator plus period, wrapping at 32 bits in 32-bit mode.
- R12: A one-shot hit disarms the channel, so it does not hit again while the counter holds. A channel is armed again by a comparator write made while the enable is high, or by a rising edge of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| idx | input | IDX_W | Channel index |
| offset | input | 5 | Byte offset within the channel |
| wr_data | input | 32 | Write data |
| main_cnt | input | 64 | Shared main counter value |
| glob_en | input | 1 | Global enable |
| rd_data | output | 32 | Registered read data |
| match_o | output | NUM_TIMERS | Per-channel match pulse |

## Verification
The hardest situation to reach is a one-shot channel sitting on a counter value that does not move. Only the armed state stops it from hitting again, and that state cannot be read. The bench builds this case by parking `main_cnt` on the comparator value and then writing that same value with the enable on. It watches `match_o` for one cycle high followed by several low cycles. It then re-arms the channel twice: once by a comparator write, and once by an enable toggle after a write made while disabled. A periodic 64-bit reload is used to show the period contents indirectly, since the period has no read path.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  localparam int REG_W = 32;
  localparam int CNT_W = 64;
  localparam int OFF_W = 5;

  // Channel register offsets.
  localparam logic [OFF_W-1:0] OFF_CFG_LO = 5'h00;
  localparam logic [OFF_W-1:0] OFF_CFG_HI = 5'h04;
  localparam logic [OFF_W-1:0] OFF_CMP_LO = 5'h08;
  localparam logic [OFF_W-1:0] OFF_CMP_HI = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_RT_LO  = 5'h10;
  localparam logic [OFF_W-1:0] OFF_RT_HI  = 5'h14;

  // Configuration bit positions.
  localparam int B_IRQ  = 2;
  localparam int B_PER  = 3;
  localparam int B_PCAP = 4;
  localparam int B_SCAP = 5;
  localparam int B_SETV = 6;
  localparam int B_M32  = 8;

  typedef enum logic [2:0] {
    SEL_CFG_LO, SEL_CFG_HI, SEL_CMP_LO, SEL_CMP_HI, SEL_RT_LO, SEL_RT_HI, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
    case (off)
      OFF_CFG_LO: return SEL_CFG_LO;
      OFF_CFG_HI: return SEL_CFG_HI;
      OFF_CMP_LO: return SEL_CMP_LO;
      OFF_CMP_HI: return SEL_CMP_HI;
      OFF_RT_LO:  return SEL_RT_LO;
      OFF_RT_HI:  return SEL_RT_HI;
      default:    return SEL_NONE;
    endcase
  endfunction

  // Merge a config write under the capability-dependent writable mask.
  function automatic logic [REG_W-1:0] cfg_merge(input logic [REG_W-1:0] old_v,
                                                 input logic [REG_W-1:0] new_v,
                                                 input logic pcap, input logic scap);
    logic [REG_W-1:0] m;
    m = '0;
    m[B_IRQ]  = 1'b1;
    m[B_SETV] = 1'b1;
    m[B_PER]  = pcap;
    m[B_M32]  = scap;
    return (old_v & ~m) | (new_v & m);
  endfunction

  // Mask applied to a periodic low-half comparator write.
  function automatic logic [REG_W-1:0] low_mask(input logic m32);
    return m32 ? {1'b0, {(REG_W-1){1'b1}}} : {REG_W{1'b1}};
  endfunction

  function automatic logic [CNT_W-1:0] cnt_view(input logic [CNT_W-1:0] cnt, input logic m32);
    return m32 ? {{(CNT_W-REG_W){1'b0}}, cnt[REG_W-1:0]} : cnt;
  endfunction

  function automatic logic [CNT_W-1:0] cmp_advance(input logic [CNT_W-1:0] cmp,
                                                   input logic [CNT_W-1:0] per,
                                                   input logic m32);
    logic [REG_W-1:0] lo;
    lo = cmp[REG_W-1:0] + per[REG_W-1:0];
    return m32 ? {{(CNT_W-REG_W){1'b0}}, lo} : cmp + per;
  endfunction

endpackage

// File: rtl/evt_tmr_match.sv
module evt_tmr_match
  import evt_tmr_pkg::*;
(
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             m32_i,
  input  logic             armed_i,
  input  logic             glob_en_i,
  input  logic             irq_en_i,
  output logic             hit_o,
  output logic             pulse_o,
  output logic [CNT_W-1:0] adv_o
);

  logic eq_w;

  always_comb begin
    eq_w    = (cnt_view(cnt_i, m32_i) == cmp_i);
    hit_o   = glob_en_i && armed_i && eq_w;
    pulse_o = hit_o && irq_en_i;
    adv_o   = cmp_advance(cmp_i, per_i, m32_i);
  end

endmodule

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
#(
  parameter bit PCAP = 1'b0,
  parameter bit SCAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             glob_en,
  input  logic             en_rise,
  input  logic             hit,
  input  logic [CNT_W-1:0] adv,
  output logic [REG_W-1:0] cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] per_o,
  output logic             armed_o
);

  localparam logic [REG_W-1:0] CFG_RST =
    ({{(REG_W-1){1'b0}}, PCAP} << B_PCAP) | ({{(REG_W-1){1'b0}}, SCAP} << B_SCAP);
  localparam int HI_W = CNT_W - REG_W;

  logic [REG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cmp_q, per_q;
  logic             armed_q;

  logic             m32, periodic;
  logic             wr_cfg, wr_cmp_lo, wr_cmp_hi_any, wr_cmp_hi, cmp_wr, trunc;
  logic [REG_W-1:0] cfg_next, lo_val;

  always_comb begin
    m32           = cfg_q[B_M32];
    periodic      = cfg_q[B_PER];
    wr_cfg        = wr_stb && (sel == SEL_CFG_LO);
    wr_cmp_lo     = wr_stb && (sel == SEL_CMP_LO);
    wr_cmp_hi_any = wr_stb && (sel == SEL_CMP_HI);
    wr_cmp_hi     = wr_cmp_hi_any && !m32;
    cmp_wr        = wr_cmp_lo || wr_cmp_hi;
    trunc         = wr_cfg && wdata[B_M32] && SCAP;
    cfg_next      = cfg_merge(cfg_q, wdata, PCAP, SCAP);
    lo_val        = periodic ? (wdata & low_mask(m32)) : wdata;
  end

  // Configuration word.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (wr_cfg) begin
      cfg_q <= cfg_next;
    end else if (cmp_wr) begin
      cfg_q[B_SETV] <= 1'b0;
    end
  end

  // Comparator and period: register writes win over a reload.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '1;
      per_q <= '0;
    end else if (wr_cmp_lo) begin
      cmp_q[REG_W-1:0] <= lo_val;
      if (periodic) per_q[REG_W-1:0] <= lo_val;
    end else if (wr_cmp_hi) begin
      cmp_q[CNT_W-1:REG_W] <= wdata[HI_W-1:0];
      if (periodic) per_q[CNT_W-1:REG_W] <= wdata[HI_W-1:0];
    end else if (trunc) begin
      cmp_q[CNT_W-1:REG_W] <= '0;
      per_q[CNT_W-1:REG_W] <= '0;
    end else if (hit && periodic) begin
      cmp_q <= adv;
    end
  end

  // Arming.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if ((cmp_wr && glob_en) || en_rise) begin
      armed_q <= 1'b1;
    end else if (hit && !periodic) begin
      armed_q <= 1'b0;
    end
  end

  assign cfg_o   = cfg_q;
  assign cmp_o   = cmp_q;
  assign per_o   = per_q;
  assign armed_o = armed_q;

  // R2
  a_r2_per_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !PCAP) |=> $stable(cfg_q[B_PER]));
  // R3
  a_r3_m32_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !SCAP) |=> !cfg_q[B_M32]);
  // R4
  a_r4_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    trunc |=> (cmp_q[CNT_W-1:REG_W] == '0) && (per_q[CNT_W-1:REG_W] == '0));
  // R6
  a_r6_setv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !cfg_q[B_SETV]);
  // R7
  a_r7_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp_hi_any && m32 && !hit) |=> $stable(cmp_q));
  // R11
  a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && periodic && !m32 && !cmp_wr && !trunc) |=> cmp_q == $past(cmp_q) + $past(per_q));
  // R12
  a_r12_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !periodic && !cmp_wr && !en_rise) |=> !armed_q);

endmodule

// File: rtl/evt_tmr_rdmux.sv
module evt_tmr_rdmux
  import evt_tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int IDX_W      = 5
) (
  input  logic [REG_W-1:0] cfg_i [NUM_TIMERS],
  input  logic [CNT_W-1:0] cmp_i [NUM_TIMERS],
  input  logic [IDX_W-1:0] idx,
  input  logic             idx_ok,
  input  reg_sel_e         sel,
  output logic [REG_W-1:0] rd_o
);

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (idx_ok && (idx == IDX_W'(i))) begin
        case (sel)
          SEL_CFG_LO: rd_o = cfg_i[i];
          SEL_CMP_LO: rd_o = cmp_i[i][REG_W-1:0];
          SEL_CMP_HI: rd_o = cmp_i[i][CNT_W-1:REG_W];
          default:    rd_o = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/evt_timer_cmp.sv
module evt_timer_cmp
  import evt_tmr_pkg::*;
#(
  parameter int                  NUM_TIMERS = 3,
  parameter int                  IDX_W      = 5,
  parameter logic [NUM_TIMERS-1:0] PER_CAP  = 3'b011,
  parameter logic [NUM_TIMERS-1:0] SIZE_CAP = 3'b101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      idx,
  input  logic [OFF_W-1:0]      offset,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [CNT_W-1:0]      main_cnt,
  input  logic                  glob_en,
  output logic [REG_W-1:0]      rd_data,
  output logic [NUM_TIMERS-1:0] match_o
);

  reg_sel_e         sel;
  logic             idx_ok, en_q, en_rise;
  logic [REG_W-1:0] rd_next;
  logic [REG_W-1:0] cfg_w [NUM_TIMERS];
  logic [CNT_W-1:0] cmp_w [NUM_TIMERS];

  always_comb begin
    sel     = decode_off(offset);
    idx_ok  = (int'(idx) < NUM_TIMERS);
    en_rise = glob_en && !en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= glob_en;
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
    logic             wr_stb, hit, armed;
    logic [CNT_W-1:0] per, adv;

    assign wr_stb = wr_en && idx_ok && (idx == IDX_W'(i));

    evt_tmr_regs #(.PCAP(PER_CAP[i]), .SCAP(SIZE_CAP[i])) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .sel     (sel),
      .wdata   (wr_data),
      .glob_en (glob_en),
      .en_rise (en_rise),
      .hit     (hit),
      .adv     (adv),
      .cfg_o   (cfg_w[i]),
      .cmp_o   (cmp_w[i]),
      .per_o   (per),
      .armed_o (armed)
    );

    evt_tmr_match u_match (
      .cnt_i     (main_cnt),
      .cmp_i     (cmp_w[i]),
      .per_i     (per),
      .m32_i     (cfg_w[i][B_M32]),
      .armed_i   (armed),
      .glob_en_i (glob_en),
      .irq_en_i  (cfg_w[i][B_IRQ]),
      .hit_o     (hit),
      .pulse_o   (match_o[i]),
      .adv_o     (adv)
    );
  end

  evt_tmr_rdmux #(.NUM_TIMERS(NUM_TIMERS), .IDX_W(IDX_W)) u_rdmux (
    .cfg_i  (cfg_w),
    .cmp_i  (cmp_w),
    .idx    (idx),
    .idx_ok (idx_ok),
    .sel    (sel),
    .rd_o   (rd_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  // R9
  a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !idx_ok) |=> rd_data == '0);
  // R8
  a_r8_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (sel == SEL_CFG_HI || sel == SEL_RT_LO || sel == SEL_RT_HI || sel == SEL_NONE))
      |=> rd_data == '0);
  // R10
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> match_o == '0);

endmodule

// File: tb/evt_timer_cmp_tb.sv
module evt_timer_cmp_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;

  typedef struct packed {
    logic        wr;
    logic [4:0]  idx;
    logic [4:0]  off;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd0, 5'h00, 32'h0, 32'h0000_0030, 8'd1},  // R1 ch0 caps
    '{1'b0, 5'd1, 5'h00, 32'h0, 32'h0000_0010, 8'd1},  // R1 ch1 caps
    '{1'b0, 5'd2, 5'h00, 32'h0, 32'h0000_0020, 8'd1},  // R1 ch2 caps
    '{1'b0, 5'd0, 5'h08, 32'h0, 32'hFFFF_FFFF, 8'd1},  // R1 cmp low
    '{1'b0, 5'd0, 5'h0C, 32'h0, 32'hFFFF_FFFF, 8'd1},  // R1 cmp high
    '{1'b1, 5'd2, 5'h00, 32'h108, 32'h0, 8'd2},        // R2 periodic on non-capable
    '{1'b0, 5'd2, 5'h00, 32'h0, 32'h0000_0120, 8'd2},  // R2
    '{1'b0, 5'd2, 5'h0C, 32'h0, 32'h0, 8'd4},          // R4 truncated high
    '{1'b0, 5'd2, 5'h08, 32'h0, 32'hFFFF_FFFF, 8'd4},  // R4 low kept
    '{1'b1, 5'd1, 5'h00, 32'h108, 32'h0, 8'd3},        // R3 mode32 forced 0
    '{1'b0, 5'd1, 5'h00, 32'h0, 32'h0000_0018, 8'd3},  // R3
    '{1'b1, 5'd0, 5'h00, 32'h14C, 32'h0, 8'd5},
    '{1'b0, 5'd0, 5'h00, 32'h0, 32'h0000_017C, 8'd5},  // R5 setup
    '{1'b1, 5'd0, 5'h08, 32'h8000_0010, 32'h0, 8'd5},
    '{1'b0, 5'd0, 5'h08, 32'h0, 32'h0000_0010, 8'd5},  // R5 bit31 cleared
    '{1'b0, 5'd0, 5'h00, 32'h0, 32'h0000_013C, 8'd6},  // R6 setval cleared
    '{1'b1, 5'd0, 5'h0C, 32'h1234, 32'h0, 8'd7},
    '{1'b0, 5'd0, 5'h0C, 32'h0, 32'h0, 8'd7},          // R7 ignored in mode32
    '{1'b0, 5'd0, 5'h08, 32'h0, 32'h0000_0010, 8'd7},  // R7 low untouched
    '{1'b1, 5'd0, 5'h04, 32'hFFFF_FFFF, 32'h0, 8'd8},
    '{1'b0, 5'd0, 5'h04, 32'h0, 32'h0, 8'd8},          // R8
    '{1'b0, 5'd0, 5'h00, 32'h0, 32'h0000_013C, 8'd8},  // R8 config unchanged
    '{1'b1, 5'd0, 5'h10, 32'hFFFF_FFFF, 32'h0, 8'd8},
    '{1'b0, 5'd0, 5'h10, 32'h0, 32'h0, 8'd8},          // R8
    '{1'b0, 5'd0, 5'h14, 32'h0, 32'h0, 8'd8},          // R8
    '{1'b0, 5'd0, 5'h18, 32'h0, 32'h0, 8'd8},          // R8 unknown offset
    '{1'b1, 5'd3, 5'h08, 32'h5, 32'h0, 8'd9},
    '{1'b0, 5'd3, 5'h08, 32'h0, 32'h0, 8'd9},          // R9
    '{1'b0, 5'd7, 5'h00, 32'h0, 32'h0, 8'd9},          // R9
    '{1'b1, 5'd1, 5'h00, 32'h48, 32'h0, 8'd6},
    '{1'b0, 5'd1, 5'h00, 32'h0, 32'h0000_0058, 8'd6},  // R6 setval set
    '{1'b1, 5'd1, 5'h08, 32'h8000_0005, 32'h0, 8'd5},
    '{1'b0, 5'd1, 5'h08, 32'h0, 32'h8000_0005, 8'd5},  // R5 64-bit unmasked
    '{1'b1, 5'd1, 5'h0C, 32'h2, 32'h0, 8'd7},
    '{1'b0, 5'd1, 5'h0C, 32'h0, 32'h2, 8'd7},          // R7 high written
    '{1'b0, 5'd1, 5'h00, 32'h0, 32'h0000_0018, 8'd6}   // R6 cleared by writes
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, glob_en = 1'b0;
  logic [4:0]    idx = '0;
  logic [4:0]    offset = '0;
  logic [31:0]   wr_data = '0;
  logic [63:0]   main_cnt = '0;
  logic [31:0]   rd_data;
  logic [NT-1:0] match_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx),
    .offset(offset), .wr_data(wr_data), .main_cnt(main_cnt), .glob_en(glob_en),
    .rd_data(rd_data), .match_o(match_o)
  );

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp,
                     input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] i, input logic [4:0] o, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; idx = i; offset = o; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [4:0] i, input logic [4:0] o, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; idx = i; offset = o;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk(1, 32'(match_o), 32'h0, "no match after reset"); // R1

    foreach (VEC[k]) begin
      if (VEC[k].wr) do_wr(VEC[k].idx, VEC[k].off, VEC[k].dat);
      else begin
        do_rd(VEC[k].idx, VEC[k].off, rv);
        chk(int'(VEC[k].req), rv, VEC[k].exp, $sformatf("vector %0d", k));
      end
    end

    // R10: disabled, counter low half equals ch0 comparator
    @(negedge clk); main_cnt = 64'h1_0000_0010;
    #1 chk(10, 32'(match_o), 32'h0, "no match while disabled");
    // R10: enable rise arms, 32-bit compare ignores high counter bits
    @(negedge clk); glob_en = 1'b1;
    @(negedge clk); #1 chk(10, 32'(match_o), 32'h1, "ch0 match on low half");
    @(negedge clk); #1 chk(11, 32'(match_o), 32'h0, "ch0 quiet after reload");
    do_rd(5'd0, 5'h08, rv); chk(11, rv, 32'h20, "ch0 cmp advanced");
    // R11 second period
    @(negedge clk); main_cnt = 64'h1_0000_0020;
    #1 chk(11, 32'(match_o), 32'h1, "ch0 second match");
    @(negedge clk); #1 chk(11, 32'(match_o), 32'h0, "ch0 quiet again");
    do_rd(5'd0, 5'h08, rv); chk(11, rv, 32'h30, "ch0 cmp advanced twice");
    // R10 pulse gated by bit 2; R11 64-bit reload uses full period
    @(negedge clk); main_cnt = 64'h2_8000_0005;
    #1 chk(10, 32'(match_o), 32'h0, "ch1 hit without pulse enable");
    do_rd(5'd1, 5'h08, rv); chk(11, rv, 32'h0000_000A, "ch1 cmp low after reload");
    do_rd(5'd1, 5'h0C, rv); chk(11, rv, 32'h5, "ch1 cmp high after reload");

    // R12 one-shot on ch2
    do_wr(5'd2, 5'h00, 32'h104);
    do_rd(5'd2, 5'h00, rv); chk(12, rv, 32'h124, "ch2 config");
    @(negedge clk); main_cnt = 64'h7_0000_0050;
    do_wr(5'd2, 5'h08, 32'h50);
    #1 chk(12, 32'(match_o), 32'h4, "ch2 one-shot fires");
    @(negedge clk); #1 chk(12, 32'(match_o), 32'h0, "ch2 no refire");
    @(negedge clk); #1 chk(12, 32'(match_o), 32'h0, "ch2 still disarmed");
    do_wr(5'd2, 5'h08, 32'h50);
    #1 chk(12, 32'(match_o), 32'h4, "ch2 rearmed by write");
    @(negedge clk); #1 chk(12, 32'(match_o), 32'h0, "ch2 disarmed again");
    // R12 rearm by enable edge after a write while disabled
    @(negedge clk); glob_en = 1'b0;
    do_wr(5'd2, 5'h08, 32'h50);
    #1 chk(10, 32'(match_o), 32'h0, "ch2 quiet while disabled");
    @(negedge clk); glob_en = 1'b1;
    @(negedge clk); #1 chk(12, 32'(match_o), 32'h4, "ch2 rearmed by enable rise");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule